// File: doc/BRIEF.md
# Address-Match Debug Breakpoint

This block watches the CPU address bus for one programmable address and, on a match, asks the CPU to stop and enter its halted debug state. Software programs a 16-bit match register and two control bits through a small register write port. One control bit arms the unit. The other picks between two kinds of stop.

In forced mode, any bus access to the match address arms a pending request. This covers opcode fetches, operand reads and writes. The halt request then rises at the next instruction boundary that follows.

In tagged mode, only an opcode fetch from the match address counts. That fetch marks the opcode with a tag. The halt request rises only if the marked opcode reaches the end of the instruction queue, in place of executing it. A queue flush, such as a taken branch, discards the tag without stopping.

The halt request stays high until the debug logic acknowledges it.

Top module: `brkpt_unit`

## Requirements
- R1: After reset, halt_req and tag_out are 0, the unit is disarmed, tagged mode is selected, and the match register holds 0x0000.
- R2: While the arm bit is 0, halt_req and tag_out stay 0 for any address, access, fetch, boundary or queue-end activity, whatever the match register and mode bit hold.
- R3: A write with reg_sel = 0 loads reg_wdata into the match register. A write with reg_sel = 1 loads the control bits: bit 0 is arm and bit 1 is mode (1 = forced, 0 = tagged). Writes with reg_sel = 2 or 3 change nothing.
- R4: A match requires all 16 address bits to equal the match register. An address differing in only its top bit or only its bottom bit does not match.
- R5: In forced mode, any access (cpu_acc = 1, fetch or not) to the match address arms a pending stop. halt_req rises in the cycle after the first cpu_iboundary strobe that comes after the access cycle. A boundary strobe in the same cycle as the access does not count.
- R6: In tagged mode, tag_out rises in the cycle after an opcode fetch (cpu_acc = 1 and cpu_opfetch = 1) from the match address. A non-fetch access to that address sets no tag.
- R7: When cpu_qend is 1 while tag_out is 1, halt_req rises in the next cycle and tag_out falls.
- R8: When cpu_qflush is 1 while tag_out is 1 and cpu_qend is 0, tag_out falls in the next cycle, and a later queue-end produces no halt.
- R9: Once raised, halt_req stays 1 until halt_ack is 1. An acknowledge clears halt_req and any pending forced stop in the next cycle.
- R10: Writing the arm bit to 0 drops halt_req and tag_out in the cycle after the write. It also discards pending and tagged state, so re-arming does not revive them.
- R11: Tagged mode never raises a stop on boundary strobes, and forced mode never sets tag_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 match, 1 control |
| reg_wdata | input | 16 | Register write data |
| cpu_addr | input | 16 | CPU address bus |
| cpu_acc | input | 1 | Bus access valid this cycle |
| cpu_opfetch | input | 1 | Current access is an opcode fetch |
| cpu_iboundary | input | 1 | Instruction boundary strobe |
| cpu_qend | input | 1 | Tagged opcode reached the queue end |
| cpu_qflush | input | 1 | Instruction queue flushed |
| halt_ack | input | 1 | Debug halt acknowledge |
| tag_out | output | 1 | Tag bit for the fetched opcode |
| halt_req | output | 1 | Request to enter halted debug mode |

## Verification
The two functions that can land in the same cycle are arming a forced stop and consuming it at an instruction boundary. The bench provokes this by driving a matching access together with cpu_iboundary. It then judges that halt_req stays low after that edge and rises only after the following boundary strobe. A second overlap, a fetch and a flush in neighbouring cycles, is judged by the absence of any halt at the later queue end.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int unsigned SEL_W        = 2;
    localparam int unsigned SEL_MATCH    = 0;
    localparam int unsigned SEL_CTRL     = 1;
    localparam int unsigned CTRL_ARM_BIT = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;

    typedef struct packed {
        logic arm;
        logic forced;
    } brk_ctrl_t;

    typedef struct packed {
        logic pend;
        logic tag;
        logic halt;
    } brk_seq_t;

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     sel,
    input  logic [AW-1:0]        wdata,
    output logic [AW-1:0]        match_val,
    output brk_ctrl_t            ctrl
);

    typedef struct packed {
        logic [AW-1:0] match_val;
        brk_ctrl_t     ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (sel == SEL_W'(SEL_MATCH)) begin
                r_d.match_val = wdata;
            end else if (sel == SEL_W'(SEL_CTRL)) begin
                r_d.ctrl.arm    = wdata[CTRL_ARM_BIT];
                r_d.ctrl.forced = wdata[CTRL_MODE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign match_val = r_q.match_val;
    assign ctrl      = r_q.ctrl;

    // R3: control bits move only on a control write
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_W'(SEL_CTRL)) |=> $stable(ctrl));

    // R3: match value moves only on a match write
    p_match_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_W'(SEL_MATCH)) |=> $stable(match_val));

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] match_val,
    output logic          hit
);

    logic [AW-1:0] bit_eq;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_eq[i] = ~(addr[i] ^ match_val[i]);
    end

    assign hit = &bit_eq;

endmodule

// File: rtl/brk_seq.sv
module brk_seq
    import brk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  brk_ctrl_t ctrl,
    input  logic      hit,
    input  logic      acc,
    input  logic      opfetch,
    input  logic      boundary,
    input  logic      qend,
    input  logic      qflush,
    input  logic      ack,
    output logic      halt_req,
    output logic      tag_out
);

    brk_seq_t s_d, s_q;
    logic     force_hit;
    logic     fetch_hit;
    logic     fire_forced;
    logic     fire_tagged;

    always_comb begin
        force_hit   = ctrl.arm &  ctrl.forced & acc & hit;
        fetch_hit   = ctrl.arm & ~ctrl.forced & acc & opfetch & hit;
        fire_forced = s_q.pend & boundary;
        fire_tagged = s_q.tag & qend;
        s_d = s_q;
        if (!ctrl.arm) begin
            s_d = '0;
        end else begin
            s_d.halt = (s_q.halt & ~ack) | fire_forced | fire_tagged;
            s_d.pend = force_hit | (s_q.pend & ~ack & ~fire_forced);
            s_d.tag  = fetch_hit | (s_q.tag & ~qflush & ~qend);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign halt_req = s_q.halt & ctrl.arm;
    assign tag_out  = s_q.tag  & ctrl.arm;

    // R10: a disarmed cycle wipes all sequencing state
    p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.arm |=> (s_q == '0));

    // R5: a pending stop meeting a boundary raises the halt
    p_forced_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.arm && s_q.pend && boundary) |=> s_q.halt);

    // R7: tagged opcode at queue end turns into a halt
    p_tag_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.arm && s_q.tag && qend && !(acc && opfetch && hit)) |=> (s_q.halt && !s_q.tag));

    // R8: a flush drops the tag
    p_flush_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.arm && s_q.tag && qflush && !qend && !(acc && opfetch && hit)) |=> !s_q.tag);

    // R9: halt holds until acknowledged
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.arm && s_q.halt && !ack) |=> s_q.halt);

    // R9: acknowledge clears halt when nothing re-fires
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !(s_q.pend && boundary) && !(s_q.tag && qend)) |=> !s_q.halt);

    // R6: no new tag without an opcode fetch
    p_tag_needs_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(acc && opfetch) && !s_q.tag) |=> !s_q.tag);

endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
    import brk_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [AW-1:0]    reg_wdata,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_acc,
    input  logic             cpu_opfetch,
    input  logic             cpu_iboundary,
    input  logic             cpu_qend,
    input  logic             cpu_qflush,
    input  logic             halt_ack,
    output logic             tag_out,
    output logic             halt_req
);

    logic [AW-1:0] match_val;
    brk_ctrl_t     ctrl;
    logic          hit;

    brk_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .match_val (match_val),
        .ctrl      (ctrl)
    );

    brk_cmp #(.AW(AW)) u_cmp (
        .addr      (cpu_addr),
        .match_val (match_val),
        .hit       (hit)
    );

    brk_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .hit      (hit),
        .acc      (cpu_acc),
        .opfetch  (cpu_opfetch),
        .boundary (cpu_iboundary),
        .qend     (cpu_qend),
        .qflush   (cpu_qflush),
        .ack      (halt_ack),
        .halt_req (halt_req),
        .tag_out  (tag_out)
    );

    // R2: disarmed unit never requests
    p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && !ctrl.arm) |=> (!halt_req && !tag_out));

endmodule

// File: tb/sim_brkpt_unit.sv
module sim_brkpt_unit;

    logic        clk = 0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] cpu_addr;
    logic        cpu_acc, cpu_opfetch, cpu_iboundary, cpu_qend, cpu_qflush, halt_ack;
    logic        tag_out, halt_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    brkpt_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cpu_addr(cpu_addr), .cpu_acc(cpu_acc), .cpu_opfetch(cpu_opfetch),
        .cpu_iboundary(cpu_iboundary), .cpu_qend(cpu_qend), .cpu_qflush(cpu_qflush),
        .halt_ack(halt_ack), .tag_out(tag_out), .halt_req(halt_req)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        reg_we = 0; reg_sel = 0; reg_wdata = 0; cpu_addr = 16'h0;
        cpu_acc = 0; cpu_opfetch = 0; cpu_iboundary = 0;
        cpu_qend = 0; cpu_qflush = 0; halt_ack = 0;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] data);
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        step();
        reg_we = 0;
    endtask

    task automatic access(logic [15:0] a, logic fetch);
        cpu_addr = a; cpu_acc = 1; cpu_opfetch = fetch;
        step();
        cpu_acc = 0; cpu_opfetch = 0;
    endtask

    task automatic pulse_boundary();
        cpu_iboundary = 1; step(); cpu_iboundary = 0;
    endtask

    task automatic pulse_qend();
        cpu_qend = 1; step(); cpu_qend = 0;
    endtask

    task automatic pulse_ack();
        halt_ack = 1; step(); halt_ack = 0;
    endtask

    task automatic clean();
        idle();
        wr(2'd1, 16'h0000);
        step();
    endtask

    task automatic t_reset();
        chk("R1", "halt after reset", halt_req, 1'b0);
        chk("R1", "tag after reset", tag_out, 1'b0);
        // arm forced only: match still 0x0000 from reset
        wr(2'd1, 16'h0003);
        access(16'h0000, 1'b0);
        pulse_boundary();
        chk("R1", "match resets to zero", halt_req, 1'b1);
        clean();
    endtask

    task automatic t_disabled();
        wr(2'd0, 16'h55AA);
        wr(2'd1, 16'h0002);
        access(16'h55AA, 1'b1);
        pulse_boundary();
        chk("R2", "forced while disarmed", halt_req, 1'b0);
        wr(2'd1, 16'h0000);
        access(16'h55AA, 1'b1);
        chk("R2", "tag while disarmed", tag_out, 1'b0);
        pulse_qend();
        chk("R2", "qend while disarmed", halt_req, 1'b0);
        clean();
    endtask

    task automatic t_reg_decode();
        wr(2'd0, 16'h4000);
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'hFFFF);
        wr(2'd3, 16'h0002);
        access(16'hFFFF, 1'b1);
        chk("R3", "sel 2 leaves match", tag_out, 1'b0);
        access(16'h4000, 1'b1);
        chk("R3", "sel 3 leaves mode tagged", tag_out, 1'b1);
        clean();
    endtask

    task automatic t_compare_bits();
        wr(2'd0, 16'h8001);
        wr(2'd1, 16'h0001);
        access(16'h0001, 1'b1);
        chk("R4", "top bit differs", tag_out, 1'b0);
        access(16'h8000, 1'b1);
        chk("R4", "bottom bit differs", tag_out, 1'b0);
        access(16'h8001, 1'b1);
        chk("R4", "exact match", tag_out, 1'b1);
        clean();
    endtask

    task automatic t_forced();
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h0003);
        access(16'h1234, 1'b0);
        chk("R5", "no halt before boundary", halt_req, 1'b0);
        step(); step();
        chk("R5", "pending waits", halt_req, 1'b0);
        pulse_boundary();
        chk("R5", "halt after boundary", halt_req, 1'b1);
        step(); step();
        chk("R9", "halt holds", halt_req, 1'b1);
        pulse_ack();
        chk("R9", "ack clears halt", halt_req, 1'b0);
        pulse_boundary();
        chk("R9", "ack cleared pending", halt_req, 1'b0);
        clean();
    endtask

    task automatic t_forced_same_cycle();
        wr(2'd0, 16'h00F0);
        wr(2'd1, 16'h0003);
        cpu_addr = 16'h00F0; cpu_acc = 1; cpu_iboundary = 1;
        step();
        cpu_acc = 0; cpu_iboundary = 0;
        chk("R5", "same-cycle boundary ignored", halt_req, 1'b0);
        pulse_boundary();
        chk("R5", "next boundary fires", halt_req, 1'b1);
        clean();
    endtask

    task automatic t_tagged();
        wr(2'd0, 16'h2000);
        wr(2'd1, 16'h0001);
        access(16'h2000, 1'b0);
        chk("R6", "data access sets no tag", tag_out, 1'b0);
        access(16'h2000, 1'b1);
        chk("R6", "fetch sets tag", tag_out, 1'b1);
        chk("R7", "no halt before qend", halt_req, 1'b0);
        pulse_qend();
        chk("R7", "qend raises halt", halt_req, 1'b1);
        chk("R7", "qend drops tag", tag_out, 1'b0);
        pulse_ack();
        chk("R9", "ack clears tagged halt", halt_req, 1'b0);
        clean();
    endtask

    task automatic t_flush();
        wr(2'd0, 16'h3000);
        wr(2'd1, 16'h0001);
        access(16'h3000, 1'b1);
        cpu_qflush = 1; step(); cpu_qflush = 0;
        chk("R8", "flush drops tag", tag_out, 1'b0);
        pulse_qend();
        chk("R8", "no halt after flush", halt_req, 1'b0);
        clean();
    endtask

    task automatic t_mode_isolation();
        wr(2'd0, 16'h7777);
        wr(2'd1, 16'h0001);
        access(16'h7777, 1'b0);
        pulse_boundary();
        chk("R11", "tagged ignores boundary", halt_req, 1'b0);
        wr(2'd1, 16'h0003);
        access(16'h7777, 1'b1);
        chk("R11", "forced sets no tag", tag_out, 1'b0);
        clean();
    endtask

    task automatic t_disarm();
        wr(2'd0, 16'hABCD);
        wr(2'd1, 16'h0003);
        access(16'hABCD, 1'b0);
        pulse_boundary();
        chk("R10", "halt raised", halt_req, 1'b1);
        wr(2'd1, 16'h0002);
        chk("R10", "disarm drops halt", halt_req, 1'b0);
        wr(2'd1, 16'h0003);
        chk("R10", "re-arm no stale halt", halt_req, 1'b0);
        access(16'hABCD, 1'b0);
        wr(2'd1, 16'h0002);
        wr(2'd1, 16'h0003);
        pulse_boundary();
        chk("R10", "pending discarded", halt_req, 1'b0);
        wr(2'd1, 16'h0001);
        access(16'hABCD, 1'b1);
        wr(2'd1, 16'h0000);
        chk("R10", "disarm drops tag", tag_out, 1'b0);
        wr(2'd1, 16'h0001);
        pulse_qend();
        chk("R10", "tag discarded", halt_req, 1'b0);
        clean();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        summary();
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_disabled();
        t_reg_decode();
        t_compare_bits();
        t_forced();
        t_forced_same_cycle();
        t_tagged();
        t_flush();
        t_mode_isolation();
        t_disarm();
        summary();
        $finish;
    end

endmodule